// File: doc/BRIEF.md
# Dual-Mode Serial Memory Mode Controller

This block decides which bus personality a small serial memory presents. After power-on the memory streams its contents on a dedicated transmit clock and takes no part in two-wire bus traffic. A falling edge on SCL moves it into a trial state. The trial state is taken only while the shifter has released SDA. In the trial state the block counts transmit-clock rising edges. If no acknowledged two-wire command arrives within 128 of them, the block falls back to streaming. One transmit-clock edge later it raises a strobe that restarts the stream at address 00h.

The block also watches SDA and SCL for START and STOP conditions and counts address bits. The address decoder acknowledges a matching device code, and the block accepts that acknowledge only at the end of a complete address byte. Once it has accepted one, it locks into two-wire mode until reset. It then keeps the bus released for a set number of system cycles before it signals that bus transfers may begin. The three raw lines SCL, SDA and VCLK each pass through a two-flop synchronizer inside the block.

Top module: `dualmode_ctrl`

## Requirements
- R1: After a synchronous active-low reset, mode_o is 0 (streaming), vclk_cnt_o is 0, and restart_o and bus_en_o are low. The mode encoding is 0 for streaming, 1 for the trial state and 2 for locked two-wire mode.
- R2: In streaming mode, a synchronized falling edge of SCL moves the block to the trial state and clears the counter, but only while sda_oe_i is low. With sda_oe_i high the edge is ignored.
- R3: In the trial state, each synchronized VCLK rising edge adds one to vclk_cnt_o. Each synchronized SCL falling edge clears it, and the clear wins when both edges arrive in the same cycle.
- R4: When the count reaches 128, the block returns to streaming mode. The counter saturates at 128 and never wraps.
- R5: After that return, the next VCLK rising edge (the 129th) pulses restart_o for one cycle. No further pulse follows until another recovery.
- R6: An acknowledge accepted in the trial state moves the block to mode 2, and it stays there until reset. In mode 2, SCL and VCLK edges leave the mode and the counter unchanged.
- R7: cmd_ack_i counts only while a frame is open and exactly 8 SCL rising edges have followed its START. In any other case it is ignored. A command with no acknowledge, such as a wrong device code, leaves the count running, so recovery at 128 still takes place.
- R8: A START (SDA falls while SCL is high) opens a frame and clears the bit count. A STOP (SDA rises while SCL is high) closes it. An acknowledge after a STOP inside the address byte is therefore ignored, and the block can still return to streaming.
- R9: bus_en_o stays low for HOLD_CYC system cycles after entry into mode 2, then goes high and stays high. bus_en_o is never high outside mode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Raw SCL line |
| sda_i | input | 1 | Raw SDA line |
| vclk_i | input | 1 | Raw transmit clock |
| sda_oe_i | input | 1 | Stream shifter is driving SDA |
| cmd_ack_i | input | 1 | Address decoder acknowledges a matching device code |
| mode_o | output | 2 | Current mode (0 streaming, 1 trial, 2 two-wire locked) |
| vclk_cnt_o | output | 8 | Recovery counter value |
| restart_o | output | 1 | One-cycle strobe: restart streaming at address 00h |
| bus_en_o | output | 1 | Two-wire transfers allowed after the hold period |

## Verification
The assertions assume that each raw line holds its level for at least three system cycles, so the synchronizers see every edge exactly once. They also assume that SDA changes only while SCL is low, except when the bench means to make a START or STOP. The bench holds every level for four cycles and moves SDA inside the SCL low phase during address bits. It pulses cmd_ack_i for a single cycle, both inside and outside the acknowledge window. A behavioural model in the bench applies the same synchronizer delay to the raw lines and is compared with the design on every cycle.

// File: rtl/dualmode_pkg.sv
// Package: shared mode encoding for the dual-mode controller.
// Assumes: two bits are enough for the three modes.
package dualmode_pkg;
    typedef enum logic [1:0] {
        MODE_STREAM = 2'd0,
        MODE_TRIAL  = 2'd1,
        MODE_BUS    = 2'd2
    } dm_mode_e;
endpackage

// File: rtl/dualmode_sync.sv
// Module: two-flop synchronizer for W independent lines, plus a third
// stage that holds the previous synchronized value for edge detection.
// Assumes: each input level is held for at least three clk cycles.
module dualmode_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    for (genvar g = 0; g < W; g++) begin : g_line
        logic st1_q, st2_q, st3_q;
        // Shift the raw line through the sync stages; idle-high after reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st1_q <= 1'b1;
                st2_q <= 1'b1;
                st3_q <= 1'b1;
            end else begin
                st1_q <= raw_i[g];
                st2_q <= st1_q;
                st3_q <= st2_q;
            end
        end
        assign cur_o[g]  = st2_q;
        assign prev_o[g] = st3_q;
    end
endmodule

// File: rtl/dualmode_busmon.sv
// Module: detects START/STOP, tracks the open frame and counts address
// bits, and says when an acknowledge falls in the address ack window.
// Assumes: synchronized current/previous SCL and SDA values.
module dualmode_busmon #(
    parameter int BITS_W = 4,
    parameter int ADDR_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_cur,
    input  logic scl_prev,
    input  logic sda_cur,
    input  logic sda_prev,
    input  logic cmd_ack_i,
    output logic ack_ok_o
);
    localparam logic [BITS_W-1:0] BITS_MAX = '1;

    logic              scl_hi, start_ev, stop_ev, scl_rise;
    logic              frame_q;
    logic [BITS_W-1:0] bits_q;

    // Condition decode from the synchronized line pair
    always_comb begin
        scl_hi   = scl_cur && scl_prev;
        start_ev = scl_hi && sda_prev && !sda_cur;
        stop_ev  = scl_hi && !sda_prev && sda_cur;
        scl_rise = scl_cur && !scl_prev;
    end

    // Frame open/close and saturating address-bit count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= 1'b0;
            bits_q  <= '0;
        end else if (start_ev) begin
            frame_q <= 1'b1;
            bits_q  <= '0;
        end else if (stop_ev) begin
            frame_q <= 1'b0;
        end else if (scl_rise && frame_q && bits_q != BITS_MAX) begin
            bits_q <= bits_q + 1'b1;
        end
    end

    assign ack_ok_o = cmd_ack_i && frame_q && (bits_q == BITS_W'(ADDR_BITS));

    // R8
    frame_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !frame_q);
    // R8
    frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (frame_q && bits_q == '0));
endmodule

// File: rtl/dualmode_fsm.sv
// Module: mode state machine with saturating recovery counter, restart
// strobe and post-entry bus hold timer.
// Assumes: edge inputs are single-cycle pulses from the synchronizer.
module dualmode_fsm
    import dualmode_pkg::*;
#(
    parameter int REC_CLKS = 128,
    parameter int HOLD_CYC = 16,
    parameter int CNT_W    = $clog2(REC_CLKS) + 1,
    parameter int HOLD_W   = $clog2(HOLD_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_fall,
    input  logic             vclk_rise,
    input  logic             sda_oe_i,
    input  logic             ack_ok,
    output logic [1:0]       mode_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             restart_o,
    output logic             bus_en_o
);
    localparam logic [CNT_W-1:0]  CNT_TOP  = CNT_W'(REC_CLKS);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(REC_CLKS - 1);
    localparam logic [HOLD_W-1:0] HOLD_INIT = HOLD_W'(HOLD_CYC);

    dm_mode_e          mode_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [HOLD_W-1:0] hold_q;
    logic              pend_q, restart_q;

    // Mode transitions, counter, pending restart and hold timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_STREAM;
            cnt_q     <= '0;
            hold_q    <= '0;
            pend_q    <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            restart_q <= 1'b0;
            case (mode_q)
                MODE_STREAM: begin
                    if (scl_fall && !sda_oe_i) begin
                        mode_q <= MODE_TRIAL;
                        cnt_q  <= '0;
                        pend_q <= 1'b0;
                    end else if (vclk_rise && pend_q) begin
                        restart_q <= 1'b1;
                        pend_q    <= 1'b0;
                    end
                end
                MODE_TRIAL: begin
                    if (ack_ok) begin
                        mode_q <= MODE_BUS;
                        hold_q <= HOLD_INIT;
                    end else if (scl_fall) begin
                        cnt_q <= '0;
                    end else if (vclk_rise) begin
                        if (cnt_q == CNT_LAST) begin
                            cnt_q  <= CNT_TOP;
                            mode_q <= MODE_STREAM;
                            pend_q <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                MODE_BUS: begin
                    if (hold_q != '0) hold_q <= hold_q - 1'b1;
                end
                default: mode_q <= MODE_STREAM;
            endcase
        end
    end

    assign mode_o    = mode_q;
    assign cnt_o     = cnt_q;
    assign restart_o = restart_q;
    assign bus_en_o  = (mode_q == MODE_BUS) && (hold_q == '0);

    // R6
    bus_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_BUS) |=> (mode_q == MODE_BUS));
    // R4
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_TOP);
    // R5
    restart_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_q |-> (mode_q == MODE_STREAM));
    // R2
    no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STREAM) |=> (mode_q != MODE_BUS));
    // R9
    bus_en_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en_o |-> (mode_q == MODE_BUS));
    // R3
    cnt_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STREAM) |=> (mode_q != MODE_STREAM || $stable(cnt_q)));
endmodule

// File: rtl/dualmode_ctrl.sv
// Module: top of the dual-mode controller; synchronizes the raw lines,
// monitors the two-wire bus and runs the mode state machine.
// Assumes: raw lines are asynchronous to clk; sda_oe_i and cmd_ack_i are
// already in the clk domain.
module dualmode_ctrl #(
    parameter int REC_CLKS = 128,
    parameter int HOLD_CYC = 16,
    parameter int CNT_W    = $clog2(REC_CLKS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             vclk_i,
    input  logic             sda_oe_i,
    input  logic             cmd_ack_i,
    output logic [1:0]       mode_o,
    output logic [CNT_W-1:0] vclk_cnt_o,
    output logic             restart_o,
    output logic             bus_en_o
);
    localparam int IDX_SCL = 0;
    localparam int IDX_SDA = 1;
    localparam int IDX_VCK = 2;

    logic [2:0] cur, prev;
    logic       scl_fall, vclk_rise, ack_ok;

    dualmode_sync #(.W(3)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({vclk_i, sda_i, scl_i}),
        .cur_o  (cur),
        .prev_o (prev)
    );

    // Edge pulses for the state machine
    always_comb begin
        scl_fall  = prev[IDX_SCL] && !cur[IDX_SCL];
        vclk_rise = !prev[IDX_VCK] && cur[IDX_VCK];
    end

    dualmode_busmon u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_cur   (cur[IDX_SCL]),
        .scl_prev  (prev[IDX_SCL]),
        .sda_cur   (cur[IDX_SDA]),
        .sda_prev  (prev[IDX_SDA]),
        .cmd_ack_i (cmd_ack_i),
        .ack_ok_o  (ack_ok)
    );

    dualmode_fsm #(
        .REC_CLKS (REC_CLKS),
        .HOLD_CYC (HOLD_CYC),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_fall  (scl_fall),
        .vclk_rise (vclk_rise),
        .sda_oe_i  (sda_oe_i),
        .ack_ok    (ack_ok),
        .mode_o    (mode_o),
        .cnt_o     (vclk_cnt_o),
        .restart_o (restart_o),
        .bus_en_o  (bus_en_o)
    );
endmodule

// File: tb/dualmode_ctrl_test.sv
module dualmode_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int REC = 128;
    localparam int HOLD = 16;
    localparam int HL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1, vclk = 1'b0, sda_oe = 1'b0, ack = 1'b0;
    logic [1:0] mode;
    logic [7:0] cnt;
    logic restart, bus_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit chk_en = 0;

    // behavioural reference state
    int m_mode, m_cnt, m_pend, m_hold, m_rst, m_frame, m_bits;
    int h_scl[3], h_sda[3], h_vck[3];

    always #(CLK_PERIOD/2) clk = ~clk;

    dualmode_ctrl uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .vclk_i(vclk),
        .sda_oe_i(sda_oe), .cmd_ack_i(ack),
        .mode_o(mode), .vclk_cnt_o(cnt), .restart_o(restart), .bus_en_o(bus_en)
    );

    // reference model: lines seen two edges late, events from last two views
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_pend = 0; m_hold = 0; m_rst = 0;
            m_frame = 0; m_bits = 0;
            for (int i = 0; i < 3; i++) begin h_scl[i] = 1; h_sda[i] = 1; h_vck[i] = 1; end
        end else begin
            bit sfall, srise, vrise, st, sp, ackok;
            sfall = (h_scl[2] == 1) && (h_scl[1] == 0);
            srise = (h_scl[2] == 0) && (h_scl[1] == 1);
            vrise = (h_vck[2] == 0) && (h_vck[1] == 1);
            st = h_scl[2] == 1 && h_scl[1] == 1 && h_sda[2] == 1 && h_sda[1] == 0;
            sp = h_scl[2] == 1 && h_scl[1] == 1 && h_sda[2] == 0 && h_sda[1] == 1;
            ackok = ack && m_frame == 1 && m_bits == 8;
            m_rst = 0;
            if (m_mode == 0) begin
                if (sfall && !sda_oe) begin m_mode = 1; m_cnt = 0; m_pend = 0; end
                else if (vrise && m_pend == 1) begin m_rst = 1; m_pend = 0; end
            end else if (m_mode == 1) begin
                if (ackok) begin m_mode = 2; m_hold = HOLD; end
                else if (sfall) m_cnt = 0;
                else if (vrise) begin
                    m_cnt++;
                    if (m_cnt >= REC) begin m_cnt = REC; m_mode = 0; m_pend = 1; end
                end
            end else if (m_hold > 0) m_hold--;
            if (st) begin m_frame = 1; m_bits = 0; end
            else if (sp) m_frame = 0;
            else if (srise && m_frame == 1 && m_bits < 15) m_bits++;
            h_scl[2] = h_scl[1]; h_scl[1] = h_scl[0]; h_scl[0] = scl;
            h_sda[2] = h_sda[1]; h_sda[1] = h_sda[0]; h_sda[0] = sda;
            h_vck[2] = h_vck[1]; h_vck[1] = h_vck[0]; h_vck[0] = vclk;
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (chk_en) begin
            checks += 4;
            if (mode != 2'(m_mode)) begin errors++;
                $display("FAIL R2 R4 R6 R7 R8 mode: got %0d expected %0d at %0t", mode, m_mode, $time); end
            if (cnt != 8'(m_cnt)) begin errors++;
                $display("FAIL R3 R4 count: got %0d expected %0d at %0t", cnt, m_cnt, $time); end
            if (restart != 1'(m_rst)) begin errors++;
                $display("FAIL R5 restart: got %0b expected %0d at %0t", restart, m_rst, $time); end
            if (bus_en != (m_mode == 2 && m_hold == 0)) begin errors++;
                $display("FAIL R9 bus_en: got %0b expected %0b at %0t", bus_en, (m_mode == 2 && m_hold == 0), $time); end
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_pulse();
        @(negedge clk) scl = 1'b1; idle(HL);
        scl = 1'b0; idle(HL);
    endtask

    task automatic vclk_pulses(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) vclk = 1'b1; idle(HL);
            vclk = 1'b0; idle(HL);
        end
    endtask

    task automatic start_cond();
        @(negedge clk) sda = 1'b1; scl = 1'b1; idle(HL);
        sda = 1'b0; idle(HL);
        scl = 1'b0; idle(HL);
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 7; i > 7 - n; i--) begin
            @(negedge clk) sda = b[i]; idle(HL);
            scl_pulse();
        end
    endtask

    task automatic stop_cond();
        @(negedge clk) sda = 1'b0; idle(HL);
        scl = 1'b1; idle(HL);
        sda = 1'b1; idle(HL);
    endtask

    task automatic ack_pulse();
        @(negedge clk) ack = 1'b1;
        @(negedge clk) ack = 1'b0;
        idle(HL);
    endtask

    task automatic expect_mode(int exp, string tag);
        checks++;
        if (mode != 2'(exp)) begin errors++;
            $display("FAIL %s mode: got %0d expected %0d", tag, mode, exp); end
    endtask

    initial begin
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        chk_en = 1;
        // R1: reset values
        checks++;
        if (mode != 0 || cnt != 0 || restart || bus_en) begin errors++;
            $display("FAIL R1 reset: got mode=%0d cnt=%0d expected 0 0", mode, cnt); end
        idle(4);
        // R2: SCL fall ignored while shifter drives SDA
        sda_oe = 1'b1;
        @(negedge clk) scl = 1'b0; idle(HL);
        expect_mode(0, "R2");
        @(negedge clk) scl = 1'b1; idle(HL);
        sda_oe = 1'b0;
        @(negedge clk) scl = 1'b0; idle(HL);
        expect_mode(1, "R2");
        // R3: counting, cleared by SCL fall
        vclk_pulses(50);
        scl_pulse();
        vclk_pulses(127);
        scl_pulse();
        // clear and VCLK rise in the same cycle
        @(negedge clk) scl = 1'b1; idle(HL);
        vclk_pulses(3);
        @(negedge clk) scl = 1'b0; vclk = 1'b1; idle(HL);
        vclk = 1'b0; idle(HL);
        // R4, R5: recovery after 128 and restart on the 129th
        vclk_pulses(128);
        expect_mode(0, "R4");
        vclk_pulses(3);
        // R8: STOP inside the address byte, late ack ignored
        start_cond();
        expect_mode(1, "R8");
        send_bits(8'hA0, 4);
        stop_cond();
        ack_pulse();
        expect_mode(1, "R8");
        @(negedge clk) scl = 1'b0; idle(HL);
        vclk_pulses(129);
        // R7: wrong device code, no ack; early ack ignored; recovery follows
        start_cond();
        send_bits(8'hC0, 5);
        ack_pulse();
        send_bits(8'h00, 3);
        expect_mode(1, "R7");
        vclk_pulses(129);
        expect_mode(0, "R7");
        // R6, R9: accepted ack locks two-wire mode
        start_cond();
        send_bits(8'hA4, 8);
        ack_pulse();
        expect_mode(2, "R6");
        idle(HOLD + 2);
        checks++;
        if (!bus_en) begin errors++; $display("FAIL R9 bus_en: got 0 expected 1"); end
        scl_pulse();
        vclk_pulses(140);
        stop_cond();
        expect_mode(2, "R6");
        idle(5);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule